// File: doc/BRIEF.md
# Bus Bridge Stop/Acknowledge Handshake Controller

This block quiesces or re-enables one side of an asynchronous bus bridge. A local requester issues a command with `cmd_valid_i`. `cmd_stop_i` = 1 asks for a stop and `cmd_stop_i` = 0 asks for a start. The block drives the level-based stop-request line into the bridge. It then waits until the bridge acknowledge, after synchronization, reaches the matching level: 1 after a stop, 0 after a start. It reports the outcome with a one-cycle `done_o` pulse. `err_o` is raised in the same cycle when the wait ran out of time.

A domain with no bridge port is handled with `port_present_i` = 0. In that case a command completes at once with success and `stop_req_o` keeps its value. On a timeout the block does not undo anything. `stop_req_o` keeps the level it was driving, and the requester decides whether to reverse the command.

Top module: `bridge_stop_ack_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `stop_req_o`, `busy_o`, `done_o` and `err_o` are all 0.
- R2: A stop command is accepted on a clock edge where the block is idle, `cmd_valid_i` = 1, `cmd_stop_i` = 1 and `port_present_i` = 1. After that edge `stop_req_o` = 1 and `busy_o` = 1. The command completes with `done_o` = 1 and `err_o` = 0 once the synchronized acknowledge reads 1.
- R3: A start command is accepted the same way with `cmd_stop_i` = 0. After the accepting edge `stop_req_o` = 0. The command completes without error once the synchronized acknowledge reads 0.
- R4: `ack_i` passes through a synchronizer of SYNC_STAGES flops, 2 by default. Take an `ack_i` level that settles before clock edge A+1 and is not already seen as the target. `done_o` is then raised after edge A+SYNC_STAGES+1.
- R5: Let E0 be the accepting edge. If the synchronized acknowledge has not matched by edge E0+TIMEOUT_CYCLES, that edge gives `done_o` = 1 with `err_o` = 1. A match that arrives exactly at edge E0+TIMEOUT_CYCLES counts as success. After a timeout, `stop_req_o` keeps the level it was driving.
- R6: With `port_present_i` = 0, an accepted command gives `done_o` = 1 and `err_o` = 0 right after the accepting edge. `busy_o` stays 0 and `stop_req_o` is unchanged.
- R7: While `busy_o` = 1, `cmd_valid_i` is ignored. It changes neither `stop_req_o` nor the cycle of completion.
- R8: If the synchronized acknowledge already equals the target level when a command is accepted, `done_o` is raised after edge E0+1 with `err_o` = 0.
- R9: `done_o` is a single-cycle pulse for each bridged command, and `busy_o` is 0 whenever `done_o` = 1. `err_o` is 0 whenever `done_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_stop_i | input | 1 | 1 = stop (quiesce) the bridge side, 0 = start it |
| port_present_i | input | 1 | 0 = no bridge port, command succeeds immediately |
| ack_i | input | 1 | Bridge acknowledge, asynchronous to clk_i |
| stop_req_o | output | 1 | Stop-request level driven into the bridge |
| busy_o | output | 1 | Waiting for the acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |

## Verification
The acknowledge is modelled as the stop-request delayed by a chosen number of cycles. Zero delay shows the synchronizer latency on its own. Moderate delays show that completion follows the bridge rather than a fixed count. A delay that lands exactly on the timeout edge, and one that lands a cycle later, separate a late success from a timeout.

An acknowledge stuck at either level, in both directions, separates three cases:
- immediate completion when the acknowledge already matches;
- a timeout that leaves the request level in place;
- the success path.

Bypass commands are issued to show that the request line is untouched. A second command is issued in the middle of a wait to show it is ignored.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } bsh_state_e;
endpackage

// File: rtl/bsh_ack_sync.sv
module bsh_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], async_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= async_i;
      end
    end
  endgenerate

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/bsh_wait_timer.sv
module bsh_wait_timer #(
  parameter int LIMIT = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  // R5: wait window never exceeds the limit
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/bsh_fsm.sv
module bsh_fsm
  import bsh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_stop_i,
  input  logic port_present_i,
  input  logic ack_sync_i,
  input  logic expired_i,
  output logic timer_clear_o,
  output logic timer_run_o,
  output logic stop_req_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  bsh_state_e state_q;
  logic stop_q, done_q, err_q;
  logic accept, match;

  assign accept = (state_q == ST_IDLE) && cmd_valid_i;
  // target level equals the request level just driven
  assign match  = (ack_sync_i == stop_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (!port_present_i) begin
              done_q <= 1'b1;
            end else begin
              stop_q  <= cmd_stop_i;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (match) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (expired_i) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign timer_clear_o = accept;
  assign timer_run_o   = (state_q == ST_WAIT);
  assign stop_req_o    = stop_q;
  assign busy_o        = (state_q == ST_WAIT);
  assign done_o        = done_q;
  assign err_o         = err_q;

  // R7: request level frozen during a wait
  assert_stop_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(stop_req_o));
  // R9: completion leaves the wait state
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/bridge_stop_ack_ctrl.sv
module bridge_stop_ack_ctrl #(
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_stop_i,
  input  logic port_present_i,
  input  logic ack_i,
  output logic stop_req_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  logic ack_sync, expired, timer_clear, timer_run;

  bsh_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ack_i),
    .sync_o  (ack_sync)
  );

  bsh_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (timer_clear),
    .run_i     (timer_run),
    .expired_o (expired)
  );

  bsh_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_stop_i     (cmd_stop_i),
    .port_present_i (port_present_i),
    .ack_sync_i     (ack_sync),
    .expired_i      (expired),
    .timer_clear_o  (timer_clear),
    .timer_run_o    (timer_run),
    .stop_req_o     (stop_req_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o)
  );

  // R5: error only reported with completion
  assert_err_with_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R6: bypass succeeds at once without touching the request
  assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && !port_present_i) |=>
      (done_o && !err_o && !busy_o && $stable(stop_req_o)));
endmodule

// File: tb/bridge_stop_ack_ctrl_test.sv
module bridge_stop_ack_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO  = 20;
  localparam int SYNC = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_stop = 0, present = 1, ack = 0;
  logic stop_req, busy, done, err;

  bridge_stop_ack_ctrl #(.SYNC_STAGES(SYNC), .TIMEOUT_CYCLES(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_stop_i(cmd_stop),
    .port_present_i(present), .ack_i(ack), .stop_req_o(stop_req),
    .busy_o(busy), .done_o(done), .err_o(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R1";

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // bridge model: acknowledge follows the request after dly cycles, or is stuck
  logic [31:0] hist = '0;
  int dly = 0;
  bit stuck = 0;
  logic stuck_val = 0;
  always @(negedge clk) begin
    hist = {hist[30:0], stop_req};
    ack  = stuck ? stuck_val : hist[dly];
  end

  // behavioural reference, stepped on each rising edge
  int  m_ackq[$];
  bit  m_busy = 0, m_stop = 0, m_done = 0, m_err = 0;
  int  m_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ackq = {};
      for (int i = 0; i < SYNC; i++) m_ackq.push_back(0);
      m_busy = 0; m_stop = 0; m_done = 0; m_err = 0; m_cnt = 0;
    end else begin
      int seen;
      seen = m_ackq[0];
      m_done = 0; m_err = 0;
      if (!m_busy) begin
        if (cmd_valid) begin
          if (!present) m_done = 1;
          else begin m_stop = cmd_stop; m_busy = 1; m_cnt = 0; end
        end
      end else begin
        m_cnt++;
        if (seen == int'(m_stop)) begin m_done = 1; m_busy = 0; end
        else if (m_cnt == TMO) begin m_done = 1; m_err = 1; m_busy = 0; end
      end
      void'(m_ackq.pop_front());
      m_ackq.push_back(int'(ack));
    end
  end

  always @(negedge clk) begin
    chk(tag, "model stop_req", int'(stop_req), int'(m_stop));
    chk(tag, "model busy", int'(busy), int'(m_busy));
    chk(tag, "model done", int'(done), int'(m_done));
    chk(tag, "model err", int'(err), int'(m_err));
  end

  task automatic run_cmd(bit stop, int exp_lat, bit exp_err, string t);
    int k;
    tag = t;
    @(negedge clk); cmd_valid = 1; cmd_stop = stop;
    @(negedge clk); cmd_valid = 0;
    k = 0;
    while (!done && k < 200) begin @(negedge clk); k++; end
    chk(t, "done latency", k, exp_lat);
    chk(t, "err", int'(err), int'(exp_err));
    @(negedge clk);
    chk(t, "done single pulse R9", int'(done), 0);
    chk(t, "err low after done R9", int'(err), 0);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", "reset stop_req", int'(stop_req), 0);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset err", int'(err), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R4: zero bridge delay exposes sync latency (SYNC+1)
    dly = 0;
    run_cmd(1, SYNC + 1, 0, "R4");
    chk("R2", "stop_req after stop", int'(stop_req), 1);
    run_cmd(0, SYNC + 1, 0, "R4");
    chk("R3", "stop_req after start", int'(stop_req), 0);
    // R2 / R3 with a delayed acknowledge
    dly = 4;
    run_cmd(1, SYNC + 1 + 4, 0, "R2");
    run_cmd(0, SYNC + 1 + 4, 0, "R3");

    // R8: acknowledge already at the target level
    stuck = 1; stuck_val = 1;
    repeat (5) @(negedge clk);
    run_cmd(1, 1, 0, "R8");
    stuck_val = 0;
    repeat (5) @(negedge clk);
    run_cmd(0, 1, 0, "R8");

    // R5: stuck acknowledge in both directions
    stuck_val = 0;
    run_cmd(1, TMO, 1, "R5");
    chk("R5", "stop_req held after stop timeout", int'(stop_req), 1);
    stuck_val = 1;
    run_cmd(0, TMO, 1, "R5");
    chk("R5", "stop_req held after start timeout", int'(stop_req), 0);
    stuck = 0;
    repeat (35) @(negedge clk);

    // R5 boundary: match exactly at the timeout edge wins
    dly = TMO - SYNC - 1;
    run_cmd(1, TMO, 0, "R5");
    run_cmd(0, TMO, 0, "R5");
    // one cycle later is a timeout
    dly = TMO - SYNC;
    run_cmd(1, TMO, 1, "R5");
    chk("R5", "stop_req kept after late ack", int'(stop_req), 1);
    dly = 0;
    run_cmd(0, SYNC + 1, 0, "R3");

    // R6: bypass
    present = 0;
    run_cmd(1, 0, 0, "R6");
    chk("R6", "stop_req untouched by bypass stop", int'(stop_req), 0);
    chk("R6", "busy stays low in bypass", int'(busy), 0);
    present = 1;
    run_cmd(1, SYNC + 1, 0, "R2");
    present = 0;
    run_cmd(0, 0, 0, "R6");
    chk("R6", "stop_req untouched by bypass start", int'(stop_req), 1);
    present = 1;
    run_cmd(0, SYNC + 1, 0, "R3");

    // R7: second command during a wait is ignored
    begin
      int k;
      tag = "R7";
      dly = 6;
      @(negedge clk); cmd_valid = 1; cmd_stop = 1;
      @(negedge clk); cmd_valid = 0;
      k = 0;
      repeat (3) begin
        chk("R7", "no early done", int'(done), 0);
        @(negedge clk); k++;
      end
      cmd_valid = 1; cmd_stop = 0;
      @(negedge clk); k++; cmd_valid = 0;
      chk("R7", "stop_req unchanged by ignored cmd", int'(stop_req), 1);
      while (!done && k < 200) begin @(negedge clk); k++; end
      chk("R7", "done latency unchanged", k, SYNC + 1 + 6);
      chk("R7", "err", int'(err), 0);
      chk("R7", "stop_req after completion", int'(stop_req), 1);
      @(negedge clk);
      chk("R7", "no extra command accepted", int'(busy), 0);
      repeat (30) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule